// File: doc/BRIEF.md
# Reset Vector Responder

This block lets a 68000-style processor start without any ROM at address zero. After reset the processor fetches two longwords, the initial supervisor stack pointer and the initial program counter, as four word reads from the bottom of the address space. The block watches the address strobe, the read/write line and the word address. While it is enabled and the fetch is not yet complete, it answers those reads on its own. It returns a single configured byte in the low data lane of words 0 and 2 and zero everywhere else. The stack pointer and the program counter therefore both start at the same address, `1 << (16 + sel)`.

The configured byte holds bits 23:16 of both longwords. A 3-bit select input picks which one of those eight bits is set. The default select value of 1 gives 0x00020000. The block raises its own acknowledge in the same cycle that it sees the strobe, and it drives the bus only while the processor is reading. After it has answered four word reads it lets go of the bus for good. Only a reset re-arms it.

Top module: `boot_vector_responder`

## Requirements
- R1: Once the synchronous active-low reset has been seen at a clock edge, and while the strobe is inactive, `bus_drive_o` and `ack_o` are 0 and `rd_data_o` is zero.
- R2: An armed, enabled read (`as_n_i`=0, `rd_ni_wr`=1) of word address 0 sets `bus_drive_o` and `ack_o` in the same cycle. It returns `rd_data_o` = {8'h00, vector byte}, where the vector byte is bits 23:16 of the initial stack pointer.
- R3: A read of word address 2 (byte address 4/5) returns the same {8'h00, vector byte}, so the initial program counter equals the initial stack pointer.
- R4: Reads of word addresses 1 and 3 are driven and acknowledged with `rd_data_o` = 16'h0000.
- R5: The vector byte is `1 << vec_sel_i`. Select k sets only bit 16+k of the start address, and select 1 gives 0x00020000.
- R6: While `enable_i` is 0 the block never drives or acknowledges, and reads in that state do not count toward the fetch.
- R7: Write cycles (`rd_ni_wr`=0) are never driven or acknowledged.
- R8: Reads of word addresses 4 and above are never driven or acknowledged, and they do not count.
- R9: A read counts when the strobe goes inactive after an answered cycle. After four counted reads the block answers nothing until the next reset, and a reset arms it again.
- R10: `rd_data_o` is zero in every cycle in which `bus_drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; arms the responder |
| enable_i | input | 1 | Responder enable |
| vec_sel_i | input | 3 | Index k of the start-address bit 16+k |
| word_addr_i | input | 23 | Word address, bits 23:1 of the byte address |
| as_n_i | input | 1 | Address strobe, active low |
| rd_ni_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| rd_data_o | output | 16 | Data to place on the processor bus |
| bus_drive_o | output | 1 | Enables the bus drivers for `rd_data_o` |
| ack_o | output | 1 | Data-transfer acknowledge, active high |

## Verification
The hardest state to reach is the permanent release after the fourth counted read. Reaching it needs a full fetch in which writes, out-of-range reads and disabled reads are mixed in but must not advance the count. The stimulus interleaves those non-counting cycles with the four real reads, then reads word 0 again and expects silence. A reset follows, and the same read must be answered. A behavioural model that keeps a fetch counter is compared with every output on every clock, and a loop walks all eight select values from a fresh reset each time.

// File: rtl/bvr_pkg.sv
// Package: shared widths and the per-cycle decode result of the reset
// vector responder. Assumes a 16-bit data bus whose low lane carries the
// vector byte.
package bvr_pkg;
    localparam int LANE_W = 8;

    typedef struct packed {
        logic hit;   // this cycle is answered by the responder
        logic even;  // word index is even: carries the vector byte
    } bvr_slot_t;
endpackage

// File: rtl/bvr_decode.sv
// Decoder: decides whether the current bus cycle is a vector read that the
// responder must answer. Assumes a word address (byte bit 0 dropped) and
// that `armed_i` comes from the fetch sequencer.
module bvr_decode
    import bvr_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int VEC_WORDS = 4
) (
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              armed_i,
    input  logic              as_n_i,
    input  logic              rd_ni_wr,
    input  logic [ADDR_W-1:1] word_addr_i,
    output bvr_slot_t         slot_o
);
    localparam logic [ADDR_W-1:1] LIMIT = (ADDR_W-1)'(VEC_WORDS);

    logic in_range;

    // Classify the cycle: enabled, armed, strobed read inside the vector words.
    always_comb begin
        in_range    = word_addr_i < LIMIT;
        slot_o.hit  = rst_n && enable_i && armed_i && !as_n_i && rd_ni_wr && in_range;
        slot_o.even = !word_addr_i[1];
    end
endmodule

// File: rtl/bvr_seq.sv
// Fetch sequencer: counts answered reads as their strobe ends and disarms
// the responder after VEC_WORDS of them. Assumes a synchronous active-low
// reset and a strobe that is held for whole clock cycles.
module bvr_seq #(
    parameter int VEC_WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n_i,
    input  logic hit_i,
    output logic armed_o
);
    localparam int CNT_W = $clog2(VEC_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(VEC_WORDS);

    logic [CNT_W-1:0] cnt_q;
    logic             hit_q;

    // Remember whether the previous cycle was answered.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_i;
    end

    // Count a read when its strobe goes inactive after an answered cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (as_n_i && hit_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Armed until the full vector fetch has been counted.
    always_comb armed_o = (cnt_q != CNT_MAX);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    p_release_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |=> !armed_o);
    p_no_hit_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |-> !hit_i);
endmodule

// File: rtl/bvr_lane.sv
// Lane former: builds the one-hot vector byte from the select index and
// places it in the low data lane for even vector words. Assumes the select
// index is at most LANE_W-1.
module bvr_lane
    import bvr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic [SEL_W-1:0]  vec_sel_i,
    input  bvr_slot_t         slot_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              bus_drive_o,
    output logic              ack_o
);
    logic [LANE_W-1:0] vec_byte;

    // One decoder bit per lane bit: set where the index points.
    for (genvar i = 0; i < LANE_W; i++) begin : g_bit
        assign vec_byte[i] = (vec_sel_i == SEL_W'(i));
    end

    // Drive the lane only for answered cycles; zero elsewhere.
    always_comb begin
        rd_data_o   = '0;
        bus_drive_o = slot_i.hit;
        ack_o       = slot_i.hit;
        if (slot_i.hit && slot_i.even) rd_data_o[LANE_W-1:0] = vec_byte;
    end
endmodule

// File: rtl/boot_vector_responder.sv
// Reset vector responder: answers the processor's first VEC_WORDS word
// reads after reset with a start address whose single set bit is chosen by
// vec_sel_i. Assumes a 16-bit bus, word addressing and a synchronous
// active-low reset.
module boot_vector_responder
    import bvr_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int SEL_W     = 3,
    parameter int VEC_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [SEL_W-1:0]  vec_sel_i,
    input  logic [ADDR_W-1:1] word_addr_i,
    input  logic              as_n_i,
    input  logic              rd_ni_wr,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              bus_drive_o,
    output logic              ack_o
);
    bvr_slot_t slot;
    logic      armed;

    bvr_decode #(.ADDR_W(ADDR_W), .VEC_WORDS(VEC_WORDS)) u_decode (
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .armed_i     (armed),
        .as_n_i      (as_n_i),
        .rd_ni_wr    (rd_ni_wr),
        .word_addr_i (word_addr_i),
        .slot_o      (slot)
    );

    bvr_seq #(.VEC_WORDS(VEC_WORDS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n_i  (as_n_i),
        .hit_i   (slot.hit),
        .armed_o (armed)
    );

    bvr_lane #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_lane (
        .vec_sel_i   (vec_sel_i),
        .slot_i      (slot),
        .rd_data_o   (rd_data_o),
        .bus_drive_o (bus_drive_o),
        .ack_o       (ack_o)
    );

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive_o |-> rd_data_o == '0);
    p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !bus_drive_o && !ack_o);
    p_quiet_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ni_wr |-> !bus_drive_o);
    p_ack_with_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_o |-> ack_o && !as_n_i);
    p_vec_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_o && !word_addr_i[1]) |-> $countones(rd_data_o) == 1);
    p_odd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_o && word_addr_i[1]) |-> rd_data_o == '0);
endmodule

// File: tb/sim_boot_vector_responder.sv
// Bench: behavioural fetch model compared with the outputs on every cycle.
module sim_boot_vector_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b1;
    logic [2:0]  vec_sel_i = 3'd1;
    logic [23:1] word_addr_i = '0;
    logic        as_n_i = 1'b1;
    logic        rd_ni_wr = 1'b1;
    logic [15:0] rd_data_o;
    logic        bus_drive_o;
    logic        ack_o;

    int total = 0;
    int bad = 0;
    int m_count = 0;
    bit m_prev = 0;

    always #10 clk = ~clk;

    boot_vector_responder u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .vec_sel_i(vec_sel_i),
        .word_addr_i(word_addr_i), .as_n_i(as_n_i), .rd_ni_wr(rd_ni_wr),
        .rd_data_o(rd_data_o), .bus_drive_o(bus_drive_o), .ack_o(ack_o)
    );

    function automatic bit model_hit();
        return rst_n && enable_i && !as_n_i && rd_ni_wr
               && (int'(word_addr_i) < 4) && (m_count < 4);
    endfunction

    // Model state update at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_count <= 0;
            m_prev  <= 0;
        end else begin
            if (as_n_i && m_prev && m_count < 4) m_count <= m_count + 1;
            m_prev <= model_hit();
        end
    end

    task automatic cyc(input bit asn, input bit rd, input int w, input string req);
        logic [15:0] ed;
        bit eh;
        @(negedge clk);
        as_n_i = asn;
        rd_ni_wr = rd;
        word_addr_i = 23'(w);
        #2;
        eh = model_hit();
        ed = (eh && (w % 2 == 0)) ? {8'h00, 8'(1 << vec_sel_i)} : 16'h0000;
        total++;
        if (rd_data_o !== ed || bus_drive_o !== eh || ack_o !== eh) begin
            bad++;
            $display("FAIL %s: data=%h drive=%b ack=%b expected data=%h drive=%b ack=%b",
                     req, rd_data_o, bus_drive_o, ack_o, ed, eh, eh);
        end
    endtask

    task automatic bus_read(input int w, input string req);
        cyc(0, 1, w, req);
        cyc(0, 1, w, req);
        cyc(1, 1, w, req);
    endtask

    task automatic bus_write(input int w, input string req);
        cyc(0, 0, w, req);
        cyc(1, 1, w, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(1, 1, 0, "R1");
        cyc(1, 1, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 0, "R1");
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();                   // R1 idle after reset
        bus_read(0, "R2");            // SP word with bit 17 (R5 default)
        bus_write(0, "R7");           // write not answered, not counted
        bus_read(5, "R8");            // beyond vector words
        bus_read(1, "R4");
        enable_i = 1'b0;
        bus_read(2, "R6");            // disabled: silent, not counted
        enable_i = 1'b1;
        bus_read(2, "R3");
        bus_read(3, "R4");            // fourth counted read
        bus_read(0, "R9");            // released
        bus_read(2, "R9");
        cyc(1, 1, 0, "R10");
        do_reset();
        bus_read(0, "R9");            // re-armed by reset
        do_reset();
        enable_i = 1'b0;
        for (int i = 0; i < 5; i++) bus_read(i % 4, "R6");
        enable_i = 1'b1;
        bus_read(0, "R6");            // still armed after disabled reads
        for (int k = 0; k < 8; k++) begin
            vec_sel_i = 3'(k);
            do_reset();
            bus_read(0, "R5");
            bus_read(2, "R5");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule